// File: doc/BRIEF.md
# Galloping Pattern Memory Test Engine

This block is a self-contained test sequencer for a one-bit-wide synchronous RAM. A pulse on `start` makes it run the galloping-pattern procedure against the RAM through a plain enable/write/address/data port. It issues every write and every read itself, one access per clock. It checks each returned bit against the value the procedure predicts, and it reports the outcome on four status outputs.

Each of the two passes begins by filling the whole array with a background value. Then every cell in turn acts as the test cell. The engine writes the inverse of the background into the test cell. It then visits every other cell in ascending order, reading that cell and reading the test cell straight after it. Finally it writes the background back into the test cell. The first pass uses background 0 and the second uses background 1. The nested loops give a run time that grows with the square of the depth. That cost buys sensitivity to interaction between any pair of cells.

A failure does not stop the run. The engine keeps the address and the pass of the first wrong read, finishes the procedure, and then holds `done`.

Top module: `gallop_tester`

## Requirements
- R1: While reset is asserted and afterwards until a start, `busy`, `done`, `fail` and `memEn` are all 0.
- R2: A `start` sampled high while idle or done makes the engine access the RAM from the next cycle onward. The first pass fills addresses 0 up to DEPTH-1 in ascending order with write data 0.
- R3: For each test cell i, taken in ascending order, the engine performs three steps in this order. It writes the inverted background to i. For every j other than i, in ascending order, it reads j and then reads i. It writes the background back to i.
- R4: After the first pass with background 0, the whole procedure runs again with background 1, starting with a fill of all cells with 1.
- R5: Exactly one RAM access is issued per cycle, for 2·DEPTH + 4·DEPTH² consecutive cycles, with `busy` high for that whole time. `memWe` is 1 for writes and 0 for reads.
- R6: Read data is taken from `memRdata` one cycle after the read is issued. The expected bit is the background for a j read and the inverted background for a test-cell read.
- R7: `fail` rises on the first mismatch and stays high. `failAddr` holds the address of that first mismatching read. `failPhase` holds its pass (0 for background 0, 1 for background 1). Later mismatches change neither field.
- R8: After a mismatch the engine still issues the full access sequence before finishing.
- R9: In the cycle after the last access, `done` goes high with `busy` low, and it stays high until the next start. A `start` while busy has no effect. A new start clears `fail`, `failAddr` and `failPhase`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run when idle or done |
| memEn | output | 1 | RAM access enable |
| memWe | output | 1 | RAM write enable (1 write, 0 read) |
| memAddr | output | AW | RAM address, AW = clog2(DEPTH) |
| memWdata | output | 1 | RAM write data |
| memRdata | input | 1 | RAM read data, valid one cycle after a read |
| busy | output | 1 | Test run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Sticky mismatch flag |
| failAddr | output | AW | Address of first mismatching read |
| failPhase | output | 1 | Background of the pass holding the first mismatch |

## Verification
A corrupted loop counter or state shows up at the RAM port in the very cycle it happens. The bench compares enable, direction, address and write data against its own expected access list on every clock, so a skipped j, an unskipped test cell or a wrong background appears as a mismatch within one access. Errors in the compare path surface only at the status outputs at the end of a run. To expose them, the bench's RAM model injects a stuck cell, a pair-dependent read inversion and a stuck cell armed only in the second pass. The bench computes the first failing read itself and checks that `failAddr` and `failPhase` match it exactly.

// File: rtl/gp_pkg.sv
package gp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SETI,
    ST_READJ,
    ST_READI,
    ST_RESTI,
    ST_DONE
  } gpState_e;

  // Strobes from control to the compare datapath
  typedef struct packed {
    logic clearFail;
    logic readStrobe;
    logic expBit;
    logic phase;
  } gpStrobe_t;

endpackage

// File: rtl/gp_ctrl.sv
module gp_ctrl
  import gp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic          memWdata,
  output logic          busy,
  output logic          done,
  output gpStrobe_t     strobe
);

  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  gpState_e      state;
  logic [CW-1:0] aCnt, iCnt, jCnt;
  logic          phase;
  logic [CW-1:0] jStep, jSkip, jFirst;
  logic          launch;

  assign launch = ((state == ST_IDLE) || (state == ST_DONE)) && start;

  // next other-cell index, stepping over the test cell
  always_comb begin
    jStep  = jCnt + 1'b1;
    jSkip  = (jStep == iCnt) ? jStep + 1'b1 : jStep;
    jFirst = (iCnt == '0) ? CW'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      aCnt  <= '0;
      iCnt  <= '0;
      jCnt  <= '0;
      phase <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state <= ST_INIT;
            phase <= 1'b0;
            aCnt  <= '0;
          end
        end
        ST_INIT: begin
          if (aCnt == LAST) begin
            state <= ST_SETI;
            iCnt  <= '0;
          end else begin
            aCnt <= aCnt + 1'b1;
          end
        end
        ST_SETI: begin
          jCnt  <= jFirst;
          state <= ST_READJ;
        end
        ST_READJ: state <= ST_READI;
        ST_READI: begin
          if (jSkip > LAST) begin
            state <= ST_RESTI;
          end else begin
            jCnt  <= jSkip;
            state <= ST_READJ;
          end
        end
        ST_RESTI: begin
          if (iCnt == LAST) begin
            if (!phase) begin
              phase <= 1'b1;
              aCnt  <= '0;
              state <= ST_INIT;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            iCnt  <= iCnt + 1'b1;
            state <= ST_SETI;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state != ST_IDLE) && (state != ST_DONE);
    done     = (state == ST_DONE);
    memEn    = busy;
    memWe    = (state == ST_INIT) || (state == ST_SETI) || (state == ST_RESTI);
    unique case (state)
      ST_INIT:  memAddr = aCnt[AW-1:0];
      ST_READJ: memAddr = jCnt[AW-1:0];
      default:  memAddr = iCnt[AW-1:0];
    endcase
    memWdata          = (state == ST_SETI) ? ~phase : phase;
    strobe.clearFail  = launch;
    strobe.readStrobe = (state == ST_READJ) || (state == ST_READI);
    strobe.expBit     = (state == ST_READI) ? ~phase : phase;
    strobe.phase      = phase;
  end

  // R3: the other-cell loop never lands on the test cell
  a_r3_skip_test_cell: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READJ) |-> (jCnt != iCnt));

  // R3: each other-cell read is followed by a read of the test cell
  a_r3_test_read_follows: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe && state == ST_READJ) |=>
      (memEn && !memWe && memAddr == iCnt[AW-1:0]));

  // R2: the fill walks addresses upward by one
  a_r2_fill_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INIT && $past(state) == ST_INIT) |->
      (memAddr == AW'($past(memAddr) + 1'b1)));

  // R9: finished engine is quiet
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !memEn));

endmodule

// File: rtl/gp_dpath.sv
module gp_dpath
  import gp_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  gpStrobe_t     strobe,
  input  logic [AW-1:0] memAddr,
  input  logic          memRdata,
  output logic          fail,
  output logic [AW-1:0] failAddr,
  output logic          failPhase
);

  logic          chkValid, chkExp, chkPhase;
  logic [AW-1:0] chkAddr;
  logic          mismatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkValid <= 1'b0;
      chkExp   <= 1'b0;
      chkPhase <= 1'b0;
      chkAddr  <= '0;
    end else begin
      chkValid <= strobe.readStrobe;
      chkExp   <= strobe.expBit;
      chkPhase <= strobe.phase;
      chkAddr  <= memAddr;
    end
  end

  assign mismatch = chkValid && (memRdata != chkExp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fail      <= 1'b0;
      failAddr  <= '0;
      failPhase <= 1'b0;
    end else if (strobe.clearFail) begin
      fail      <= 1'b0;
      failAddr  <= '0;
      failPhase <= 1'b0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      failAddr  <= chkAddr;
      failPhase <= chkPhase;
    end
  end

  // R7: the flag holds until a new run
  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strobe.clearFail) |=> fail);

  // R7: first failure record is not overwritten
  a_r7_first_kept: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strobe.clearFail) |=> ($stable(failAddr) && $stable(failPhase)));

  // R6: a failure is raised only by a compare issued the cycle before
  a_r6_fail_from_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> $past(chkValid));

endmodule

// File: rtl/gallop_tester.sv
module gallop_tester
  import gp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic          memWdata,
  input  logic          memRdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] failAddr,
  output logic          failPhase
);

  gpStrobe_t strobe;

  gp_ctrl #(.DEPTH(DEPTH), .AW(AW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .busy     (busy),
    .done     (done),
    .strobe   (strobe)
  );

  gp_dpath #(.AW(AW)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .memAddr   (memAddr),
    .memRdata  (memRdata),
    .fail      (fail),
    .failAddr  (failAddr),
    .failPhase (failPhase)
  );

  // R1: nothing touches the RAM outside a run
  a_r1_idle_no_access: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memEn);

endmodule

// File: tb/sim_gallop_tester.sv
module sim_gallop_tester;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int PASSLEN = DEPTH + 2 * DEPTH * DEPTH;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          memEn, memWe, memWdata;
  logic [AW-1:0] memAddr;
  logic          memRdata = 1'b0;
  logic          busy, done, fail, failPhase;
  logic [AW-1:0] failAddr;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  gallop_tester #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done), .fail(fail),
    .failAddr(failAddr), .failPhase(failPhase)
  );

  typedef struct {
    bit    we;
    int    addr;
    bit    data;
    bit    ph;
    string tag;
  } op_t;

  op_t q[$];

  // RAM model with fault injection
  bit mem [DEPTH];
  int faultMode = 0;  // 0 none, 1 stuck cell, 2 pair read inversion, 3 stuck armed in pass 2
  int fc = 0;
  bit sv = 1'b0;
  int agg = 0, vic = 0;
  int opIdx = 0;

  function automatic bit faultOn();
    if (faultMode == 3) return opIdx >= PASSLEN;
    return faultMode != 0;
  endfunction

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
      end else begin
        if (faultOn() && (faultMode == 1 || faultMode == 3) && int'(memAddr) == fc)
          memRdata <= sv;
        else if (faultOn() && faultMode == 2 && int'(memAddr) == vic && mem[agg] != mem[vic])
          memRdata <= ~mem[memAddr];
        else
          memRdata <= mem[memAddr];
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic buildQueue();
    q.delete();
    for (int ph = 0; ph < 2; ph++) begin
      for (int a = 0; a < DEPTH; a++)
        q.push_back('{1'b1, a, bit'(ph), bit'(ph), ph ? "R4" : "R2"});
      for (int i = 0; i < DEPTH; i++) begin
        q.push_back('{1'b1, i, ~bit'(ph), bit'(ph), ph ? "R4" : "R3"});
        for (int j = 0; j < DEPTH; j++) begin
          if (j != i) begin
            q.push_back('{1'b0, j, bit'(ph), bit'(ph), ph ? "R4" : "R3"});
            q.push_back('{1'b0, i, ~bit'(ph), bit'(ph), ph ? "R4" : "R3"});
          end
        end
        q.push_back('{1'b1, i, bit'(ph), bit'(ph), ph ? "R4" : "R3"});
      end
    end
  endtask

  task automatic runTest(int mode, int pulseAt);
    bit pendRead = 0;
    bit pendExp = 0;
    int pendAddr = 0;
    bit pendPh = 0;
    bit refFail = 0;
    int refAddr = 0;
    bit refPh = 0;
    int total;
    faultMode = mode;
    opIdx = 0;
    for (int a = 0; a < DEPTH; a++) mem[a] = 1'b0;
    buildQueue();
    total = q.size();
    check(total == 2 * DEPTH + 4 * DEPTH * DEPTH, "R5", "op list length", total,
          2 * DEPTH + 4 * DEPTH * DEPTH);
    start = 1'b1;
    @(negedge clk);
    for (int k = 0; k < total; k++) begin
      op_t o = q[k];
      start = (k == pulseAt);
      if (pendRead && memRdata != pendExp && !refFail) begin
        refFail = 1; refAddr = pendAddr; refPh = pendPh;
      end
      opIdx = k;
      check(busy && memEn, "R5", "busy/access each cycle", int'(busy && memEn), 1);
      check(memWe == o.we, o.tag, "write enable", int'(memWe), int'(o.we));
      check(int'(memAddr) == o.addr, o.tag, "address", int'(memAddr), o.addr);
      if (o.we) check(memWdata == o.data, o.tag, "write data", int'(memWdata), int'(o.data));
      pendRead = !o.we; pendExp = o.data; pendAddr = o.addr; pendPh = o.ph;
      @(negedge clk);
    end
    start = 1'b0;
    if (pendRead && memRdata != pendExp && !refFail) begin
      refFail = 1; refAddr = pendAddr; refPh = pendPh;
    end
    check(done && !busy && !memEn, "R9", "done after last access", int'(done), 1);
    check(fail == refFail, "R6", "fail flag", int'(fail), int'(refFail));
    if (refFail) begin
      check(int'(failAddr) == refAddr, "R7", "first fail address", int'(failAddr), refAddr);
      check(failPhase == refPh, "R7", "first fail pass", int'(failPhase), int'(refPh));
      check(done, "R8", "run completed after failure", int'(done), 1);
    end
    repeat (3) @(negedge clk);
    check(done && !busy, "R9", "done held while idle", int'(done), 1);
    check(fail == refFail, "R7", "fail held after done", int'(fail), int'(refFail));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !memEn, "R1", "quiet in reset", int'(busy | done | fail | memEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !fail && !memEn, "R1", "quiet after reset", int'(busy | done | fail | memEn), 0);

    // clean run, with a start pulse in the middle that must be ignored (R9)
    runTest(0, 100);
    // stuck-at-1 on an other cell: first failure in pass 0 (R6, R7)
    fc = 5; sv = 1'b1;
    runTest(1, -1);
    check(fail && failAddr == AW'(5) && !failPhase, "R7", "stuck-1 cell 5 pass 0",
          int'(failAddr), 5);
    // stuck-at-0 on cell 0: first failure on a test-cell read (R6)
    fc = 0; sv = 1'b0;
    runTest(1, -1);
    check(fail && failAddr == AW'(0), "R6", "test-cell read mismatch", int'(failAddr), 0);
    // pair-dependent read inversion
    agg = 2; vic = 7;
    runTest(2, -1);
    // stuck-at-0 armed only in second pass (R4, R7)
    fc = 9; sv = 1'b0;
    runTest(3, -1);
    check(fail && failPhase, "R4", "failure recorded in pass 1", int'(failPhase), 1);
    // restart clears failure (R9)
    runTest(0, -1);
    check(!fail && failAddr == '0 && !failPhase, "R9", "restart clears fail", int'(fail), 0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule